// File: doc/BRIEF.md
# Banked General Register File

This block holds several banks of sixteen 32-bit general registers and exposes the bank that is currently active. A 5-bit bank pointer, normally part of the processor status, picks the active bank. Software can reload the pointer only while the processor runs in its privileged (master) mode. A pointer value with no implemented bank behind it falls back to bank 0 and raises an error flag.

One combined port reads and writes a register by its 4-bit number. That port can also treat an even/odd register pair as a single 64-bit doubleword. A second read-only port supplies an index register from the range 1 to 7, where a selector of 0 means no indexing. Registers 12 to 15 of the active bank are presented together as a 128-bit accumulator for decimal operations.

All reads are combinational. A write in progress is forwarded to every read path in the same cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset the bank pointer is 0, `ptr_err` is 0 and every register of every bank reads as zero.
- R2: With `rw_dbl`=0, asserting `wr_en` stores `wr_data[31:0]` into register `rw_num` of the active bank at the rising edge. A word read returns the register in `rd_data[31:0]`, with `rd_data[63:32]` zero.
- R3: When `ptr_load` is high at a rising edge, `bank_ptr` takes `ptr_in` if `master_mode` is 1. If `master_mode` is 0, the load is ignored and `bank_ptr` keeps its value.
- R4: When `bank_ptr` is at or above `NBANKS`, `ptr_err` is 1 and bank 0 is the active bank.
- R5: Each bank is independent: a write to a register in one bank leaves the same register of every other bank unchanged.
- R6: `idx_sel`=0 gives `idx_data`=0 regardless of register 0. `idx_sel`=1..7 gives that register of the active bank.
- R7: A doubleword access (`rw_dbl`=1) with an even `rw_num` pairs it with register `rw_num`+1. The even register holds bits 63:32 and the odd register holds bits 31:0, for both read and write.
- R8: A doubleword access with an odd `rw_num` uses that single register. A write stores `wr_data[31:0]` into it and a read returns it in both halves of `rd_data`.
- R9: While `wr_en` is high, every read path (`rd_data`, `idx_data`, `dec_acc`) already shows the value being written in the same cycle.
- R10: `dec_acc` is the concatenation of registers 12, 13, 14 and 15 of the active bank, with register 12 in bits 127:96.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | Privileged mode; enables pointer loads |
| ptr_load | input | 1 | Request to load the bank pointer |
| ptr_in | input | 5 | New bank pointer value |
| bank_ptr | output | 5 | Current bank pointer |
| ptr_err | output | 1 | Pointer selects an unimplemented bank |
| rw_num | input | 4 | Register number for the read/write port |
| rw_dbl | input | 1 | Doubleword access |
| wr_en | input | 1 | Write enable |
| wr_data | input | 64 | Write data (word uses bits 31:0) |
| rd_data | output | 64 | Read data of the read/write port |
| idx_sel | input | 3 | Index register selector, 0 = none |
| idx_data | output | 32 | Index register value |
| dec_acc | output | 128 | Decimal accumulator view of registers 12 to 15 |

## Verification
Read results, the error flag and forwarded write values are combinational. They are due in the same cycle their inputs are applied. Stored writes and pointer loads become visible only after the next rising edge. The bench drives every input on the falling edge and samples outputs a quarter period later, so each check reads either the forwarded value before the edge or the stored value after exactly one edge.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int NBANKS = 2,
  parameter int W      = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master_mode,
  input  logic           ptr_load,
  input  logic [4:0]     ptr_in,
  output logic [4:0]     bank_ptr,
  output logic           ptr_err,
  input  logic [3:0]     rw_num,
  input  logic           rw_dbl,
  input  logic           wr_en,
  input  logic [2*W-1:0] wr_data,
  output logic [2*W-1:0] rd_data,
  input  logic [2:0]     idx_sel,
  output logic [W-1:0]   idx_data,
  output logic [4*W-1:0] dec_acc
);
  localparam int BSEL = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  logic [W-1:0]    rf  [NBANKS][16];
  logic [W-1:0]    cur [16];
  logic [BSEL-1:0] abank;
  logic [3:0]      pair;

  assign ptr_err = ({1'b0, bank_ptr} >= 6'(NBANKS));
  assign abank   = ptr_err ? '0 : bank_ptr[BSEL-1:0];
  assign pair    = rw_num | 4'd1;

  always_comb begin
    for (int i = 0; i < 16; i++) cur[i] = rf[abank][i];
    if (wr_en) begin
      if (rw_dbl && !rw_num[0]) begin
        cur[rw_num] = wr_data[2*W-1:W];
        cur[pair]   = wr_data[W-1:0];
      end else begin
        cur[rw_num] = wr_data[W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_ptr <= '0;
      for (int b = 0; b < NBANKS; b++)
        for (int i = 0; i < 16; i++) rf[b][i] <= '0;
    end else begin
      if (ptr_load && master_mode) bank_ptr <= ptr_in;
      if (wr_en)
        for (int i = 0; i < 16; i++) rf[abank][i] <= cur[i];
    end
  end

  assign rd_data  = !rw_dbl    ? {{W{1'b0}}, cur[rw_num]} :
                    rw_num[0]  ? {cur[rw_num], cur[rw_num]} :
                                 {cur[rw_num], cur[pair]};
  assign idx_data = (idx_sel == 3'd0) ? '0 : cur[{1'b0, idx_sel}];
  assign dec_acc  = {cur[12], cur[13], cur[14], cur[15]};
endmodule

// File: rtl/banked_regfile_checks.sv
module banked_regfile_checks #(
  parameter int NBANKS = 2,
  parameter int W      = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           master_mode,
  input logic           ptr_load,
  input logic [4:0]     ptr_in,
  input logic [4:0]     bank_ptr,
  input logic           ptr_err,
  input logic [3:0]     rw_num,
  input logic           rw_dbl,
  input logic           wr_en,
  input logic [2*W-1:0] wr_data,
  input logic [2*W-1:0] rd_data,
  input logic [2:0]     idx_sel,
  input logic [W-1:0]   idx_data,
  input logic [4*W-1:0] dec_acc
);
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_load && master_mode) |=> $stable(bank_ptr));

  p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && master_mode) |=> bank_ptr == $past(ptr_in));

  p_ptr_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && master_mode && ({1'b0, ptr_in} >= 6'(NBANKS))) |=> ptr_err);

  p_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rw_dbl) |-> rd_data[W-1:0] == wr_data[W-1:0]);

  p_persist_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rw_dbl && !ptr_load) |=>
      (!(!rw_dbl && rw_num == $past(rw_num)) || rd_data[W-1:0] == $past(wr_data[W-1:0])));

  p_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_dbl && idx_sel != 3'd0 && rw_num == {1'b0, idx_sel}) |-> idx_data == rd_data[W-1:0]);

  p_decacc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_dbl && rw_num == 4'd12) |-> dec_acc[4*W-1:3*W] == rd_data[W-1:0]);
endmodule

bind banked_regfile banked_regfile_checks #(.NBANKS(NBANKS), .W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .ptr_load(ptr_load),
  .ptr_in(ptr_in), .bank_ptr(bank_ptr), .ptr_err(ptr_err), .rw_num(rw_num),
  .rw_dbl(rw_dbl), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .idx_sel(idx_sel), .idx_data(idx_data), .dec_acc(dec_acc)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         master_mode = 1'b0, ptr_load = 1'b0;
  logic [4:0]   ptr_in = '0;
  logic [4:0]   bank_ptr;
  logic         ptr_err;
  logic [3:0]   rw_num = '0;
  logic         rw_dbl = 1'b0, wr_en = 1'b0;
  logic [63:0]  wr_data = '0;
  logic [63:0]  rd_data;
  logic [2:0]   idx_sel = '0;
  logic [31:0]  idx_data;
  logic [127:0] dec_acc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  banked_regfile uut (.*);

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] n, logic d, logic [63:0] v);
    @(negedge clk);
    rw_num = n; rw_dbl = d; wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] n, logic d);
    @(negedge clk);
    wr_en = 1'b0; rw_num = n; rw_dbl = d;
    #5;
  endtask

  task automatic load_ptr(logic m, logic [4:0] p);
    @(negedge clk);
    master_mode = m; ptr_load = 1'b1; ptr_in = p;
    @(negedge clk);
    ptr_load = 1'b0; master_mode = 1'b0;
  endtask

  task automatic t_reset;
    #5;
    chk("R1 bank_ptr", 128'(bank_ptr), 128'd0);
    chk("R1 ptr_err", 128'(ptr_err), 128'd0);
    rd(4'd3, 1'b0);
    chk("R1 r3", 128'(rd_data), 128'd0);
    chk("R1 dec_acc", dec_acc, 128'd0);
  endtask

  task automatic t_word;
    wr(4'd3, 1'b0, 64'hFFFF_FFFF_A5A5_5A5A);
    rd(4'd3, 1'b0);
    chk("R2 word r3", 128'(rd_data), 128'h0000_0000_A5A5_5A5A);
    wr(4'd0, 1'b0, 64'h0000_0000_0BAD_F00D);
    rd(4'd0, 1'b0);
    chk("R2 word r0", 128'(rd_data), 128'h0BAD_F00D);
  endtask

  task automatic t_ptr_priv;
    load_ptr(1'b0, 5'd1);
    #5 chk("R3 slave load ignored", 128'(bank_ptr), 128'd0);
    load_ptr(1'b1, 5'd1);
    #5 chk("R3 master load", 128'(bank_ptr), 128'd1);
  endtask

  task automatic t_banks;
    rd(4'd3, 1'b0);
    chk("R5 bank1 r3 untouched", 128'(rd_data), 128'd0);
    wr(4'd3, 1'b0, 64'h1111_2222);
    load_ptr(1'b1, 5'd0);
    rd(4'd3, 1'b0);
    chk("R5 bank0 r3 kept", 128'(rd_data), 128'hA5A5_5A5A);
  endtask

  task automatic t_oob;
    load_ptr(1'b1, 5'd5);
    #5;
    chk("R4 ptr_err", 128'(ptr_err), 128'd1);
    chk("R3 ptr value", 128'(bank_ptr), 128'd5);
    rd(4'd3, 1'b0);
    chk("R4 falls back to bank0", 128'(rd_data), 128'hA5A5_5A5A);
    load_ptr(1'b1, 5'd0);
    #5 chk("R4 ptr_err clear", 128'(ptr_err), 128'd0);
  endtask

  task automatic t_index;
    @(negedge clk); idx_sel = 3'd0; #5;
    chk("R6 idx none", 128'(idx_data), 128'd0);
    idx_sel = 3'd3; #1;
    chk("R6 idx r3", 128'(idx_data), 128'hA5A5_5A5A);
  endtask

  task automatic t_dbl;
    wr(4'd4, 1'b1, 64'h0123_4567_89AB_CDEF);
    rd(4'd4, 1'b0);
    chk("R7 even high", 128'(rd_data), 128'h0123_4567);
    rd(4'd5, 1'b0);
    chk("R7 odd low", 128'(rd_data), 128'h89AB_CDEF);
    rd(4'd4, 1'b1);
    chk("R7 dbl read", 128'(rd_data), 128'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_dbl_odd;
    wr(4'd7, 1'b1, 64'hDEAD_BEEF_CAFE_F00D);
    rd(4'd7, 1'b0);
    chk("R8 odd dbl write", 128'(rd_data), 128'hCAFE_F00D);
    rd(4'd6, 1'b0);
    chk("R8 r6 untouched", 128'(rd_data), 128'd0);
    rd(4'd7, 1'b1);
    chk("R8 odd dbl read", 128'(rd_data), 128'hCAFE_F00D_CAFE_F00D);
  endtask

  task automatic t_fwd;
    @(negedge clk);
    rw_num = 4'd2; rw_dbl = 1'b0; wr_en = 1'b1; wr_data = 64'h7777_1234; idx_sel = 3'd2;
    #5;
    chk("R9 rd forward", 128'(rd_data), 128'h7777_1234);
    chk("R9 idx forward", 128'(idx_data), 128'h7777_1234);
    @(negedge clk); wr_en = 1'b0; #5;
    chk("R9 stored", 128'(rd_data), 128'h7777_1234);
  endtask

  task automatic t_dec;
    wr(4'd12, 1'b1, 64'h1212_1212_1313_1313);
    wr(4'd14, 1'b1, 64'h1414_1414_1515_1515);
    @(negedge clk); #5;
    chk("R10 dec_acc", dec_acc, 128'h1212_1212_1313_1313_1414_1414_1515_1515);
    @(negedge clk);
    rw_num = 4'd15; rw_dbl = 1'b0; wr_en = 1'b1; wr_data = 64'h0000_0009;
    #5 chk("R9 R10 dec forward", dec_acc, 128'h1212_1212_1313_1313_1414_1414_0000_0009);
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_word;
    t_ptr_priv;
    t_banks;
    t_oob;
    t_index;
    t_dbl;
    t_dbl_odd;
    t_fwd;
    t_dec;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule